// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit byte logical address into a physical address and a set of access-rights bits. It does this by reading two page-table entries from word-addressed memory. The top 10 bits of the logical address select an entry in a first-level table. The next 10 bits select an entry in a second-level table. The low 12 bits are the byte offset inside a 4096-byte page, and they pass through untranslated. The first-level table sits at a page frame supplied on the `root_frame` input, which is sampled when a request is accepted.

A processor-side request/response handshake starts a walk, and only one walk runs at a time. The walker issues memory reads through a valid/ready port and waits for a one-cycle data strobe. Bit 0 of a first-level entry is its present flag. If that flag is clear, the walk ends after a single read with a fault. Otherwise the upper 20 bits of the first-level entry name the frame of the second-level table. The second-level entry supplies a 20-bit frame in its upper bits and 12 rights bits in its lower bits.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.
- R2: A request is accepted only while the walker is idle. A `req_valid` presented during a walk is ignored: the response of the running walk reflects only the accepted address, and `req_ready` stays 0 until that response is taken.
- R3: The first memory read uses address {root frame, logical bits 31:22, 2'b00}.
- R4: When bit 0 of the first-level entry is 0, the walker issues no second read. It responds with `rsp_fault`=1, `rsp_paddr`=0 and `rsp_rights`=0.
- R5: When bit 0 of the first-level entry is 1, the second read uses address {first-level entry bits 31:12, logical bits 21:12, 2'b00}.
- R6: A successful walk responds with `rsp_fault`=0, `rsp_paddr` = {second-level entry bits 31:12, logical bits 11:0}, and `rsp_rights` = second-level entry bits 11:0.
- R7: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request stays asserted with an unchanged address.
- R8: The response holds with stable contents until `rsp_ready` is seen. The walker is idle (`req_ready`=1) in the cycle after the handshake.
- R9: `root_frame` is sampled only at request acceptance. Changes to it during a walk have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Logical byte address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Processor takes the result |
| rsp_paddr | output | 32 | Physical byte address (0 on fault) |
| rsp_rights | output | 12 | Access-rights bits (0 on fault) |
| rsp_fault | output | 1 | First-level entry not present |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the entry read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry word returned by memory |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 12-bit offset and 10-bit indices. It sweeps all 1024 first-level indices. Each walk pairs the index with a second-level index and an offset computed arithmetically, and uses a different root frame. Every seventh index has its present bit cleared, so fault walks and full walks are interleaved across the whole index range. Memory-ready delays and response-ready delays cycle through zero to two cycles. Stray requests and changes to the root frame are driven during every walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    W_IDLE,
    W_L1_REQ,
    W_L1_WAIT,
    W_L2_REQ,
    W_L2_WAIT,
    W_RESP
  } walk_state_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rd_ready,
  input  logic mem_rsp_valid,
  input  logic entry_present,
  input  logic rsp_ready,
  output logic req_ready,
  output logic accept,
  output logic rd_req,
  output logic rd_is_l2,
  output logic cap_l1,
  output logic cap_l2,
  output logic l1_absent,
  output logic rsp_valid
);
  walk_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      W_IDLE:    if (req_valid) st_d = W_L1_REQ;
      W_L1_REQ:  if (mem_rd_ready) st_d = W_L1_WAIT;
      W_L1_WAIT: if (mem_rsp_valid) st_d = entry_present ? W_L2_REQ : W_RESP;
      W_L2_REQ:  if (mem_rd_ready) st_d = W_L2_WAIT;
      W_L2_WAIT: if (mem_rsp_valid) st_d = W_RESP;
      W_RESP:    if (rsp_ready) st_d = W_IDLE;
      default:   st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= W_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready = (st_q == W_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_req    = (st_q == W_L1_REQ) || (st_q == W_L2_REQ);
  assign rd_is_l2  = (st_q == W_L2_REQ);
  assign cap_l1    = (st_q == W_L1_WAIT) && mem_rsp_valid;
  assign cap_l2    = (st_q == W_L2_WAIT) && mem_rsp_valid;
  assign l1_absent = cap_l1 && !entry_present;
  assign rsp_valid = (st_q == W_RESP);
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int L1_W        = 10,
  parameter int BYTE_W      = 2,
  parameter int PRESENT_BIT = 0,
  localparam int FRAME_W    = ADDR_W - OFF_W,
  localparam int L2_W       = ADDR_W - OFF_W - L1_W,
  localparam int RIGHTS_W   = ADDR_W - FRAME_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic [FRAME_W-1:0]  root_frame,
  input  logic                cap_l1,
  input  logic                cap_l2,
  input  logic                l1_absent,
  input  logic                rd_is_l2,
  input  logic [ADDR_W-1:0]   mem_rsp_data,
  output logic                entry_present,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic [RIGHTS_W-1:0] rsp_rights,
  output logic                rsp_fault,
  output logic [ADDR_W-1:0]   vaddr_q
);
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] tbl_q;

  function automatic logic [ADDR_W-1:0] l1_slot(input logic [FRAME_W-1:0] base,
                                                input logic [ADDR_W-1:0] va);
    return {base, va[ADDR_W-1 -: L1_W], {BYTE_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] l2_slot(input logic [FRAME_W-1:0] tbl,
                                                input logic [ADDR_W-1:0] va);
    return {tbl, va[OFF_W +: L2_W], {BYTE_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] join_phys(input logic [FRAME_W-1:0] frame,
                                                  input logic [ADDR_W-1:0] va);
    return {frame, va[OFF_W-1:0]};
  endfunction

  assign entry_present = mem_rsp_data[PRESENT_BIT];
  assign mem_rd_addr   = rd_is_l2 ? l2_slot(tbl_q, vaddr_q) : l1_slot(base_q, vaddr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr_q    <= '0;
      base_q     <= '0;
      tbl_q      <= '0;
      rsp_paddr  <= '0;
      rsp_rights <= '0;
      rsp_fault  <= 1'b0;
    end else begin
      if (accept) begin
        vaddr_q <= req_vaddr;
        base_q  <= root_frame;
      end
      if (cap_l1) tbl_q <= mem_rsp_data[ADDR_W-1 -: FRAME_W];
      if (l1_absent) begin
        rsp_paddr  <= '0;
        rsp_rights <= '0;
        rsp_fault  <= 1'b1;
      end else if (cap_l2) begin
        rsp_paddr  <= join_phys(mem_rsp_data[ADDR_W-1 -: FRAME_W], vaddr_q);
        rsp_rights <= mem_rsp_data[RIGHTS_W-1:0];
        rsp_fault  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int L1_W        = 10,
  parameter int BYTE_W      = 2,
  parameter int PRESENT_BIT = 0,
  localparam int FRAME_W    = ADDR_W - OFF_W,
  localparam int RIGHTS_W   = ADDR_W - FRAME_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FRAME_W-1:0]  root_frame,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_vaddr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic [RIGHTS_W-1:0] rsp_rights,
  output logic                rsp_fault,
  output logic                mem_rd_valid,
  input  logic                mem_rd_ready,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic                mem_rsp_valid,
  input  logic [ADDR_W-1:0]   mem_rsp_data
);
  logic              accept;
  logic              rd_is_l2;
  logic              cap_l1;
  logic              cap_l2;
  logic              l1_absent;
  logic              entry_present;
  logic [ADDR_W-1:0] vaddr_q;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .entry_present(entry_present),
    .rsp_ready    (rsp_ready),
    .req_ready    (req_ready),
    .accept       (accept),
    .rd_req       (mem_rd_valid),
    .rd_is_l2     (rd_is_l2),
    .cap_l1       (cap_l1),
    .cap_l2       (cap_l2),
    .l1_absent    (l1_absent),
    .rsp_valid    (rsp_valid)
  );

  ptw_dpath #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .L1_W       (L1_W),
    .BYTE_W     (BYTE_W),
    .PRESENT_BIT(PRESENT_BIT)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .req_vaddr    (req_vaddr),
    .root_frame   (root_frame),
    .cap_l1       (cap_l1),
    .cap_l2       (cap_l2),
    .l1_absent    (l1_absent),
    .rd_is_l2     (rd_is_l2),
    .mem_rsp_data (mem_rsp_data),
    .entry_present(entry_present),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_paddr    (rsp_paddr),
    .rsp_rights   (rsp_rights),
    .rsp_fault    (rsp_fault),
    .vaddr_q      (vaddr_q)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int RIGHTS_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rsp_fault,
  input logic [ADDR_W-1:0]   rsp_paddr,
  input logic [RIGHTS_W-1:0] rsp_rights,
  input logic                mem_rd_valid,
  input logic                mem_rd_ready,
  input logic [ADDR_W-1:0]   mem_rd_addr,
  input logic                l1_absent,
  input logic [ADDR_W-1:0]   vaddr_q
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_valid && !rsp_valid));

  p_absent_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    l1_absent |=> (rsp_valid && rsp_fault && rsp_paddr == '0 && rsp_rights == '0 && !mem_rd_valid));

  p_offset_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_rights) && $stable(rsp_fault)));

  p_rsp_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);
endmodule

bind pt_walker ptw_checker #(
  .ADDR_W  (ADDR_W),
  .OFF_W   (OFF_W),
  .RIGHTS_W(RIGHTS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_fault   (rsp_fault),
  .rsp_paddr   (rsp_paddr),
  .rsp_rights  (rsp_rights),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr (mem_rd_addr),
  .l1_absent   (l1_absent),
  .vaddr_q     (vaddr_q)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] root_frame = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [11:0] rsp_rights;
  logic        rsp_fault;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int tests = 0;
  int fails = 0;
  int rd_total = 0;

  always #2 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_rights(rsp_rights), .rsp_fault(rsp_fault),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always @(posedge clk) if (rst_n && mem_rd_valid && mem_rd_ready) rd_total <= rd_total + 1;

  function automatic logic [31:0] l1_word(input logic [31:0] a);
    logic present;
    present = (a[11:2] % 7) != 0;
    return {a[21:2] ^ 20'h5A5A5, 11'h0, present};
  endfunction

  function automatic logic [31:0] l2_word(input logic [31:0] a);
    return {a[21:2] + 20'h01357, a[13:2] ^ 12'hA5C};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] exp_addr, input string tag, input int dly,
                       input logic second, input logic [31:0] junk_base);
    logic [31:0] a0;
    while (!mem_rd_valid) @(negedge clk);
    a0 = mem_rd_addr;
    for (int k = 0; k < dly; k++) begin
      root_frame = junk_base[19:0] + 20'(k);  // R9: disturb the base mid-walk
      @(negedge clk);
      check("R7 read held", {31'd0, mem_rd_valid}, 32'd1);
      check("R7 addr stable", mem_rd_addr, a0);
    end
    check(tag, mem_rd_addr, exp_addr);
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    mem_rsp_data  = second ? l2_word(exp_addr) : l1_word(exp_addr);
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic walk(input int i);
    logic [31:0] va, e1, e2, d1, d2, exp_pa;
    logic [19:0] base;
    logic [11:0] exp_rt;
    logic        exp_ft;
    int          rd0, nrd;
    va   = {10'(i), 10'((i * 37) % 1024), 12'((i * 129) % 4096)};
    base = 20'h12345 ^ 20'(i * 3);
    check("R2 idle before request", {31'd0, req_ready}, 32'd1);
    rd0 = rd_total;
    req_valid = 1'b1; req_vaddr = va; root_frame = base;
    @(negedge clk);
    req_vaddr  = ~va;   // R2: stray request stays asserted during the walk
    root_frame = ~base; // R9
    check("R2 busy after accept", {31'd0, req_ready}, 32'd0);
    e1 = {base, va[31:22], 2'b00};
    serve(e1, "R3 first-level address", i % 3, 1'b0, 32'(~base));
    d1 = l1_word(e1);
    if (d1[0]) begin
      check("R2 busy mid-walk", {31'd0, req_ready}, 32'd0);
      e2 = {d1[31:12], va[21:12], 2'b00};
      serve(e2, "R5 second-level address", (i >> 2) % 3, 1'b1, 32'(base + 20'd7));
      d2 = l2_word(e2);
      exp_pa = {d2[31:12], va[11:0]}; exp_rt = d2[11:0]; exp_ft = 1'b0; nrd = 2;
    end else begin
      exp_pa = '0; exp_rt = '0; exp_ft = 1'b1; nrd = 1;
    end
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < (i >> 4) % 3; k++) begin
      @(negedge clk);
      check("R8 response held", {31'd0, rsp_valid}, 32'd1);
    end
    check(exp_ft ? "R4 fault paddr" : "R6 paddr", rsp_paddr, exp_pa);
    check(exp_ft ? "R4 fault rights" : "R6 rights", {20'd0, rsp_rights}, {20'd0, exp_rt});
    check(exp_ft ? "R4 fault flag" : "R6 fault flag", {31'd0, rsp_fault}, {31'd0, exp_ft});
    check(exp_ft ? "R4 single read" : "R5 two reads", 32'(rd_total - rd0), 32'(nrd));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R8 idle after handshake", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 reset mem_rd_valid", {31'd0, mem_rd_valid}, 32'd0);
    for (int i = 0; i < 1024; i++) walk(i);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule